// File: doc/BRIEF.md
# Pointer Register Address Generator

This block is the address-generation stage for indirect data-memory accesses. Each access goes through one of three 16-bit pointers held in fixed register pairs. On a request the block takes the chosen pointer and one of six adjustment modes. It returns the effective address the memory should use and, when the mode changes the pointer, the new pointer value together with a write-back enable for the register file.

The pointer pairs are X, Y and Z. X is built from R27 as the high byte and R26 as the low byte. Y is R29:R28 and Z is R31:R30. The register file presents these three 16-bit values on the pair inputs. The block registers its results, so they appear one clock after the request strobe. A mode that is not allowed on the chosen pointer raises an illegal flag and produces no access.

Top module: `ptr_addr_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `addrValid`, `wbEn` and `illegalMode` are all 0.
- R2: `ptrSel` encoding: 2'b00 selects X (`xPair`, R27:R26), 2'b01 selects Y (`yPair`, R29:R28), 2'b10 selects Z (`zPair`, R31:R30), and 2'b11 is reserved and therefore illegal. For an accepted request, `wbSel` repeats `ptrSel`.
- R3: Mode 3'b000 (plain): `addrOut` is the selected pointer and `wbEn` stays 0.
- R4: Mode 3'b001 (post-increment): `addrOut` is the old pointer, `wbData` is the pointer + 1 and `wbEn` is 1. For example, Y=0x0002 gives address 0x0002 and write-back 0x0003.
- R5: Mode 3'b010 (post-decrement): `addrOut` is the old pointer, `wbData` is the pointer − 1 and `wbEn` is 1.
- R6: Mode 3'b011 (pre-increment): `addrOut` and `wbData` are both the pointer + 1 and `wbEn` is 1. For example, Y=0x0002 gives address 0x0003.
- R7: Mode 3'b100 (pre-decrement): `addrOut` and `wbData` are both the pointer − 1 and `wbEn` is 1.
- R8: Mode 3'b101 (displacement) on Y or Z: `addrOut` is the pointer plus `disp` zero-extended from 6 bits, and `wbEn` stays 0.
- R9: Displacement on X, modes 3'b110 and 3'b111, or `ptrSel`=2'b11 give `illegalMode`=1 with `addrValid`=0 and `wbEn`=0.
- R10: Increment, decrement and displacement all wrap modulo 2^16. For example, 0xFFFF+1 gives 0x0000, 0x0000−1 gives 0xFFFF, and 0xFFF0+63 gives 0x002F.
- R11: The results appear exactly one clock after `reqValid`. In a cycle after a clock with no request, `addrValid`, `wbEn` and `illegalMode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| ptrSel | input | 2 | Pointer select (X/Y/Z) |
| mode | input | 3 | Addressing mode |
| disp | input | 6 | Unsigned displacement |
| xPair | input | 16 | Current X pointer (R27:R26) |
| yPair | input | 16 | Current Y pointer (R29:R28) |
| zPair | input | 16 | Current Z pointer (R31:R30) |
| addrOut | output | 16 | Effective address |
| addrValid | output | 1 | Effective address is valid |
| wbData | output | 16 | Updated pointer value |
| wbEn | output | 1 | Write `wbData` back to the selected pair |
| wbSel | output | 2 | Pair to write back |
| illegalMode | output | 1 | Request was rejected |

## Verification
The assertions check on every cycle the relations between ports that follow from the previous cycle's request:
- Results appear only after a strobe.
- `illegalMode` and `addrValid` are never high together.
- A write-back never happens without an access.
- Post-modes write back the address ±1, pre-modes write back the address itself, and displacement on X is rejected.

The actual address values depend on the pair contents. These include the pair mapping, the zero extension of the displacement and the wrap at the 16-bit boundary. Only the bench's reference model shows them, by replaying pointer sequences that chain each write-back into the next request.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

  typedef enum logic [2:0] {
    MODE_PLAIN   = 3'b000,
    MODE_POSTINC = 3'b001,
    MODE_POSTDEC = 3'b010,
    MODE_PREINC  = 3'b011,
    MODE_PREDEC  = 3'b100,
    MODE_DISP    = 3'b101
  } ptrMode_e;

  typedef enum logic [1:0] {
    SEL_X   = 2'b00,
    SEL_Y   = 2'b01,
    SEL_Z   = 2'b10,
    SEL_RSV = 2'b11
  } ptrSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;    // legal request: produce an access
    logic reject;    // illegal request
    logic addDisp;   // effective address = pointer + displacement
    logic useNew;    // effective address = adjusted pointer
    logic doWrite;   // write adjusted pointer back
    logic stepDown;  // adjust by -1 instead of +1
  } ctlStrobes_t;

endpackage

// File: rtl/ptr_ctrl.sv
module ptr_ctrl
  import ptr_pkg::*;
(
  input  logic        reqValid,
  input  logic [1:0]  ptrSel,
  input  logic [2:0]  mode,
  output ctlStrobes_t strobes
);

  logic selLegal;
  logic modeLegal;

  always_comb begin
    selLegal  = (ptrSel != SEL_RSV);
    modeLegal = 1'b1;
    strobes   = '0;
    case (mode)
      MODE_PLAIN:   ;
      MODE_POSTINC: strobes.doWrite = 1'b1;
      MODE_POSTDEC: begin
        strobes.doWrite  = 1'b1;
        strobes.stepDown = 1'b1;
      end
      MODE_PREINC: begin
        strobes.doWrite = 1'b1;
        strobes.useNew  = 1'b1;
      end
      MODE_PREDEC: begin
        strobes.doWrite  = 1'b1;
        strobes.useNew   = 1'b1;
        strobes.stepDown = 1'b1;
      end
      MODE_DISP: begin
        strobes.addDisp = 1'b1;
        modeLegal       = (ptrSel != SEL_X);
      end
      default: modeLegal = 1'b0;
    endcase
    strobes.accept = reqValid && selLegal && modeLegal;
    strobes.reject = reqValid && !(selLegal && modeLegal);
    if (!strobes.accept) strobes.doWrite = 1'b0;
  end

endmodule

// File: rtl/ptr_datapath.sv
module ptr_datapath
  import ptr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [1:0]        ptrSel,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] xPair,
  input  logic [ADDR_W-1:0] yPair,
  input  logic [ADDR_W-1:0] zPair,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid,
  output logic [ADDR_W-1:0] wbData,
  output logic              wbEn,
  output logic [1:0]        wbSel,
  output logic              illegalMode
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] selPtr;
  logic [ADDR_W-1:0] adjPtr;
  logic [ADDR_W-1:0] dispAddr;
  logic [ADDR_W-1:0] effAddr;

  always_comb begin
    case (ptrSel)
      SEL_Y:   selPtr = yPair;
      SEL_Z:   selPtr = zPair;
      default: selPtr = xPair;
    endcase
    adjPtr   = strobes.stepDown ? (selPtr - ONE) : (selPtr + ONE);
    dispAddr = selPtr + ADDR_W'(disp);
    if (strobes.addDisp)     effAddr = dispAddr;
    else if (strobes.useNew) effAddr = adjPtr;
    else                     effAddr = selPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut     <= '0;
      addrValid   <= 1'b0;
      wbData      <= '0;
      wbEn        <= 1'b0;
      wbSel       <= '0;
      illegalMode <= 1'b0;
    end else begin
      addrValid   <= strobes.accept;
      wbEn        <= strobes.doWrite;
      illegalMode <= strobes.reject;
      if (strobes.accept) begin
        addrOut <= effAddr;
        wbData  <= adjPtr;
        wbSel   <= ptrSel;
      end
    end
  end

endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        ptrSel,
  input  logic [2:0]        mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] xPair,
  input  logic [ADDR_W-1:0] yPair,
  input  logic [ADDR_W-1:0] zPair,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid,
  output logic [ADDR_W-1:0] wbData,
  output logic              wbEn,
  output logic [1:0]        wbSel,
  output logic              illegalMode
);

  ctlStrobes_t strobes;

  ptr_ctrl uCtrl (
    .reqValid (reqValid),
    .ptrSel   (ptrSel),
    .mode     (mode),
    .strobes  (strobes)
  );

  ptr_datapath #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .ptrSel      (ptrSel),
    .disp        (disp),
    .xPair       (xPair),
    .yPair       (yPair),
    .zPair       (zPair),
    .addrOut     (addrOut),
    .addrValid   (addrValid),
    .wbData      (wbData),
    .wbEn        (wbEn),
    .wbSel       (wbSel),
    .illegalMode (illegalMode)
  );

endmodule

// File: rtl/ptr_addr_gen_chk.sv
module ptr_addr_gen_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        ptrSel,
  input logic [2:0]        mode,
  input logic [ADDR_W-1:0] addrOut,
  input logic              addrValid,
  input logic [ADDR_W-1:0] wbData,
  input logic              wbEn,
  input logic              illegalMode
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // R11
  valid_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid || illegalMode) |-> $past(reqValid));

  // R9
  reject_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(illegalMode && (addrValid || wbEn)));

  // R3
  wb_needs_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> addrValid);

  // R4
  post_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'b001 && ptrSel != 2'b11) |=> (wbEn && wbData == addrOut + ONE));

  // R5
  post_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'b010 && ptrSel != 2'b11) |=> (wbEn && wbData == addrOut - ONE));

  // R6
  pre_adjust_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (mode == 3'b011 || mode == 3'b100) && ptrSel != 2'b11)
      |=> (wbEn && wbData == addrOut));

  // R9
  disp_on_x_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'b101 && ptrSel == 2'b00) |=> (illegalMode && !addrValid));

  // R8
  disp_no_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'b101) |=> !wbEn);

endmodule

bind ptr_addr_gen ptr_addr_gen_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .ptrSel      (ptrSel),
  .mode        (mode),
  .addrOut     (addrOut),
  .addrValid   (addrValid),
  .wbData      (wbData),
  .wbEn        (wbEn),
  .illegalMode (illegalMode)
);

// File: tb/tb_ptr_addr_gen.sv
module tb_ptr_addr_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  ptrSel = 2'b00;
  logic [2:0]  mode = 3'b000;
  logic [5:0]  disp = 6'd0;
  logic [15:0] ptrs [3];
  logic [15:0] addrOut, wbData;
  logic        addrValid, wbEn, illegalMode;
  logic [1:0]  wbSel;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // expected outputs
  logic [15:0] eAddr = 0, eWb = 0;
  logic        eValid = 0, eWbEn = 0, eIll = 0;
  logic [1:0]  eSel = 0;
  string       eTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_addr_gen dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ptrSel(ptrSel), .mode(mode),
    .disp(disp), .xPair(ptrs[0]), .yPair(ptrs[1]), .zPair(ptrs[2]),
    .addrOut(addrOut), .addrValid(addrValid), .wbData(wbData), .wbEn(wbEn),
    .wbSel(wbSel), .illegalMode(illegalMode)
  );

  // behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      eValid = 0; eWbEn = 0; eIll = 0; eAddr = 0; eWb = 0; eSel = 0; eTag = "R1";
    end else if (!reqValid) begin
      eValid = 0; eWbEn = 0; eIll = 0; eTag = "R11";
    end else begin
      int p;
      int m;
      bit bad;
      m = mode;
      bad = (ptrSel == 2'b11) || (m > 5) || (m == 5 && ptrSel == 2'b00);
      if (bad) begin
        eValid = 0; eWbEn = 0; eIll = 1; eTag = "R9";
      end else begin
        p = ptrs[ptrSel];
        eValid = 1; eIll = 0; eSel = ptrSel;
        case (m)
          0: begin eAddr = 16'(p); eWbEn = 0; eTag = "R3"; end
          1: begin eAddr = 16'(p); eWb = 16'(p + 1); eWbEn = 1; eTag = "R4"; end
          2: begin eAddr = 16'(p); eWb = 16'(p - 1); eWbEn = 1; eTag = "R5"; end
          3: begin eWb = 16'(p + 1); eAddr = eWb; eWbEn = 1; eTag = "R6"; end
          4: begin eWb = 16'(p - 1); eAddr = eWb; eWbEn = 1; eTag = "R7"; end
          default: begin eAddr = 16'(p + int'(disp)); eWbEn = 0; eTag = "R8"; end
        endcase
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check(eTag, "addrValid", addrValid, eValid);
    check(eTag, "wbEn", wbEn, eWbEn);
    check(eTag, "illegalMode", illegalMode, eIll);
    if (eValid) begin
      check(eTag, "addrOut", addrOut, eAddr);
      check("R2", "wbSel", wbSel, eSel);
    end
    if (eWbEn) check(eTag, "wbData", wbData, eWb);
  endtask

  // one clock: compare, apply write-back, drive next request
  task automatic step(bit rq, logic [1:0] s, logic [2:0] m, logic [5:0] d);
    @(negedge clk);
    compareAll();
    if (eWbEn && rstN) ptrs[eSel] = eWb;
    reqValid = rq; ptrSel = s; mode = m; disp = d;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    mismatched++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    ptrs[0] = 16'h1000; ptrs[1] = 16'h0002; ptrs[2] = 16'hFFF0;
    repeat (3) @(negedge clk);
    compareAll(); // R1 during reset
    rstN = 1'b1;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);             // R1 after release
    // R4 example: Y=2 -> addr 2, Y=3
    step(1, 2'b01, 3'b001, 0);
    step(0, 0, 0, 0);
    // R6 example: Y=3 -> addr 4
    step(1, 2'b01, 3'b011, 0);
    step(1, 2'b00, 3'b000, 0);    // R3 plain X, back-to-back
    step(1, 2'b00, 3'b010, 0);    // R5 X postdec
    step(0, 0, 0, 0);
    step(1, 2'b10, 3'b100, 0);    // R7 Z predec
    step(0, 0, 0, 0);
    step(1, 2'b10, 3'b101, 6'd63); // R8/R10 Z disp wrap
    step(1, 2'b01, 3'b101, 6'd5);  // R8 Y disp
    step(1, 2'b00, 3'b101, 6'd5);  // R9 disp on X
    step(1, 2'b11, 3'b000, 0);     // R9 reserved select
    step(1, 2'b01, 3'b110, 0);     // R9 reserved mode
    step(1, 2'b10, 3'b111, 0);     // R9 reserved mode
    step(0, 0, 0, 0);
    // R10 wrap: set pointers to edges
    @(negedge clk); compareAll();
    ptrs[0] = 16'hFFFF; ptrs[1] = 16'h0000; ptrs[2] = 16'hFFFF;
    step(1, 2'b00, 3'b001, 0);     // X FFFF -> 0000
    step(0, 0, 0, 0);
    step(1, 2'b01, 3'b100, 0);     // Y 0000 -> FFFF
    step(0, 0, 0, 0);
    step(1, 2'b10, 3'b011, 0);     // Z FFFF -> 0000
    step(0, 0, 0, 0);
    // mixed walk over all modes and pointers, chaining write-backs
    for (int i = 0; i < 60; i++) begin
      step(1, 2'(i % 3), 3'(i % 8), 6'((i * 13) % 64));
      step(0, 0, 0, 0);
    end
    // reset in the middle
    step(1, 2'b01, 3'b001, 0);
    rstN = 1'b0;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    rstN = 1'b1;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    finish();
  end

endmodule